// File: doc/BRIEF.md
# M/N:D Fractional Clock Divider

This block derives a slower clock from its input clock. Every N input cycles it produces exactly M output pulses, and the high time of its output is set by a duty value D. The three values arrive in the encodings that software writes into the configuration registers. M is given plainly. N is given as the bit-inverted difference N minus M. D is given bit-inverted. All three share one counter width. The block decodes them, checks that they make sense, and either runs its modulo accumulator or passes the input clock straight through.

The divider is built around an accumulator that adds M every input cycle, modulo N. A wrap of the accumulator raises the per-cycle enable. The divided clock is high while the accumulator sits below D. A new setting from the inputs takes effect only when the accumulator wraps back to zero, so a period in progress is never cut short. When the divider is idle in bypass, a new setting takes effect on the next edge. There is no data stream here, so every pin is a plain control or clock pin with no handshake.

Top module: `mnd_divider`

## Requirements
- R1: While reset is asserted, and after it until a valid setting is loaded, the block is in bypass: `en_o` is 1 and `clk_o` equals `clk`.
- R2: The true N is decoded as ((~n_i) + m_i) modulo 2^W. The bench encodes n_i as ~(N - M), masked to W bits.
- R3: The true D is decoded as ~d_i, masked to W bits.
- R4: The divider runs only when mode_i is nonzero, the decoded N is nonzero, and 0 < M < N. Otherwise it is in bypass, with `en_o` 1 every cycle and `clk_o` = `clk`.
- R5: While running with M and N, `en_o` is high in exactly M of any N consecutive cycles, and the accumulator always stays below N.
- R6: While running with M and N coprime, `clk_o` is high in exactly min(D, N) of any N consecutive cycles. It is low in every cycle where the accumulator is at or above D.
- R7: While running, changed inputs are ignored until the accumulator wraps to zero. The active M, N and D stay stable until then.
- R8: From bypass, a valid setting is loaded on the next clock edge. In the first cycle after that edge, `en_o` is 0 and `clk_o` is 1 exactly when D is nonzero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Mode field; zero selects bypass |
| m_i | input | W | M value, plain |
| n_i | input | W | N value, encoded as ~(N - M) |
| d_i | input | W | Duty value, encoded as ~D |
| clk_o | output | 1 | Divided clock, or `clk` in bypass |
| en_o | output | 1 | One-cycle enable on each accumulator wrap; 1 in bypass |

## Verification
The assertions assume that mode and the three encoded values change only between clock edges. They also assume that a running setting has M strictly below N, which is the condition under which the accumulator bound and the duty relation hold. The stimulus moves the inputs only at falling edges. It holds each setting long enough for the previous period to wrap before measuring a window. It uses coprime M and N wherever the duty count is checked, and it reaches the invalid settings (M equal to N, M above N, M zero, N zero) only to confirm bypass.

// File: rtl/mnd_pkg.sv
package mnd_pkg;
  localparam int MODE_W = 2;
  typedef enum logic {PATH_PASS = 1'b0, PATH_DIV = 1'b1} path_e;
endpackage

// File: rtl/mnd_decode.sv
module mnd_decode #(
  parameter int W = 8
) (
  input  logic [mnd_pkg::MODE_W-1:0] mode_i,
  input  logic [W-1:0]               m_i,
  input  logic [W-1:0]               n_i,
  input  logic [W-1:0]               d_i,
  output logic [W-1:0]               m_o,
  output logic [W-1:0]               n_o,
  output logic [W-1:0]               d_o,
  output logic                       ok_o
);
  // N register carries the inverted difference; add M back modulo 2^W
  always_comb begin
    m_o  = m_i;
    n_o  = (~n_i) + m_i;
    d_o  = ~d_i;
    ok_o = (mode_i != '0) && (n_o != '0) && (m_i != '0) && (m_i < n_o);
  end
endmodule

// File: rtl/mnd_accum.sv
module mnd_accum #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] m_new,
  input  logic [W-1:0] n_new,
  input  logic [W-1:0] d_new,
  input  logic         ok_new,
  output logic         run_q,
  output logic [W-1:0] acc_q,
  output logic [W-1:0] m_a,
  output logic [W-1:0] n_a,
  output logic [W-1:0] d_a,
  output logic         tick_q,
  output logic         level_q,
  output logic         reload
);
  localparam int SW = W + 1;

  logic [SW-1:0] sum;
  logic          wrap;
  logic [W-1:0]  acc_n;

  always_comb begin
    sum    = {1'b0, acc_q} + {1'b0, m_a};
    wrap   = sum >= {1'b0, n_a};
    acc_n  = wrap ? W'(sum - {1'b0, n_a}) : sum[W-1:0];
    reload = !run_q || (acc_n == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      acc_q   <= '0;
      m_a     <= '0;
      n_a     <= '0;
      d_a     <= '0;
      tick_q  <= 1'b0;
      level_q <= 1'b0;
    end else if (reload) begin
      run_q   <= ok_new;
      m_a     <= m_new;
      n_a     <= n_new;
      d_a     <= d_new;
      acc_q   <= '0;
      tick_q  <= run_q && wrap;
      level_q <= ok_new && (d_new != '0);
    end else begin
      acc_q   <= acc_n;
      tick_q  <= wrap;
      level_q <= acc_n < d_a;
    end
  end
endmodule

// File: rtl/mnd_divider.sv
module mnd_divider #(
  parameter int W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [mnd_pkg::MODE_W-1:0] mode_i,
  input  logic [W-1:0]               m_i,
  input  logic [W-1:0]               n_i,
  input  logic [W-1:0]               d_i,
  output logic                       clk_o,
  output logic                       en_o
);
  import mnd_pkg::*;

  logic [W-1:0] m_dec, n_dec, d_dec;
  logic         cfg_ok;
  logic         run_a, tick_q, level_q, reload;
  logic [W-1:0] acc_q, m_a, n_a, d_a;
  path_e        path;

  mnd_decode #(.W(W)) u_dec (
    .mode_i(mode_i), .m_i(m_i), .n_i(n_i), .d_i(d_i),
    .m_o(m_dec), .n_o(n_dec), .d_o(d_dec), .ok_o(cfg_ok)
  );

  mnd_accum #(.W(W)) u_acc (
    .clk(clk), .rst_n(rst_n),
    .m_new(m_dec), .n_new(n_dec), .d_new(d_dec), .ok_new(cfg_ok),
    .run_q(run_a), .acc_q(acc_q), .m_a(m_a), .n_a(n_a), .d_a(d_a),
    .tick_q(tick_q), .level_q(level_q), .reload(reload)
  );

  always_comb begin
    path  = run_a ? PATH_DIV : PATH_PASS;
    clk_o = (path == PATH_DIV) ? level_q : clk;
    en_o  = (path == PATH_DIV) ? tick_q : 1'b1;
  end
endmodule

// File: rtl/mnd_divider_chk.sv
module mnd_divider_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         run_a,
  input logic         reload,
  input logic         cfg_ok,
  input logic         clk_o,
  input logic [W-1:0] acc_q,
  input logic [W-1:0] m_a,
  input logic [W-1:0] n_a,
  input logic [W-1:0] d_a
);
  // R5
  acc_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_a |-> (acc_q < n_a));

  // R7
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_a && !reload) |=> ($stable(m_a) && $stable(n_a) && $stable(d_a)));

  // R4
  byp_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_a && !cfg_ok) |=> !run_a);

  // R6
  duty_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_a && (acc_q >= d_a)) |-> !clk_o);
endmodule

bind mnd_divider mnd_divider_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_a(run_a), .reload(reload), .cfg_ok(cfg_ok),
  .clk_o(clk_o), .acc_q(acc_q), .m_a(m_a), .n_a(n_a), .d_a(d_a)
);

// File: tb/mnd_divider_test.sv
`timescale 1ns/1ps
module mnd_divider_test;
  localparam int W = 8;
  localparam int NV = 12;
  // fields: mode, M, N, D, window, expected ticks, expected high count
  localparam logic [55:0] VEC [NV] = '{
    {8'd2, 8'd1,   8'd8,   8'd4,  8'd8,   8'd1,   8'd4},
    {8'd2, 8'd3,   8'd8,   8'd4,  8'd8,   8'd3,   8'd4},
    {8'd2, 8'd5,   8'd7,   8'd3,  8'd7,   8'd5,   8'd3},
    {8'd1, 8'd7,   8'd16,  8'd1,  8'd16,  8'd7,   8'd1},
    {8'd3, 8'd2,   8'd5,   8'd0,  8'd5,   8'd2,   8'd0},
    {8'd2, 8'd3,   8'd10,  8'd12, 8'd10,  8'd3,   8'd10},
    {8'd2, 8'd100, 8'd201, 8'd50, 8'd201, 8'd100, 8'd50},
    {8'd0, 8'd3,   8'd8,   8'd4,  8'd8,   8'd8,   8'd0},
    {8'd2, 8'd8,   8'd8,   8'd4,  8'd8,   8'd8,   8'd0},
    {8'd2, 8'd5,   8'd3,   8'd1,  8'd8,   8'd8,   8'd0},
    {8'd2, 8'd0,   8'd8,   8'd3,  8'd8,   8'd8,   8'd0},
    {8'd2, 8'd5,   8'd0,   8'd1,  8'd8,   8'd8,   8'd0}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   mode_i = '0;
  logic [W-1:0] m_i = '0, n_i = '0, d_i = '0;
  logic         clk_o, en_o;
  int           n_chk = 0, n_bad = 0;
  bit           done = 0;

  mnd_divider #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .m_i(m_i), .n_i(n_i),
    .d_i(d_i), .clk_o(clk_o), .en_o(en_o)
  );

  always #4 clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_cfg(input int md, input int m, input int n, input int d);
    mode_i = 2'(md);
    m_i    = W'(m);
    n_i    = ~W'(n - m);
    d_i    = ~W'(d);
  endtask

  task automatic finish_run();
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      finish_run();
    end
  end

  initial begin
    int ticks, highs, ok;
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 en_o in reset", int'(en_o), 1);
    check("R1 clk_o low phase in reset", int'(clk_o), 0);
    #4;
    check("R1 clk_o high phase in reset", int'(clk_o), 1);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 en_o after reset", int'(en_o), 1);

    // table walk: R2, R3, R4, R5, R6
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      set_cfg(int'(VEC[i][55:48]), int'(VEC[i][47:40]), int'(VEC[i][39:32]),
              int'(VEC[i][31:24]));
      repeat (420) @(negedge clk);
      ticks = 0;
      highs = 0;
      for (int c = 0; c < int'(VEC[i][23:16]); c++) begin
        @(negedge clk);
        ticks += int'(en_o);
        highs += int'(clk_o);
      end
      check($sformatf("R2/R4/R5 ticks vec %0d", i), ticks, int'(VEC[i][15:8]));
      check($sformatf("R3/R4/R6 high count vec %0d", i), highs, int'(VEC[i][7:0]));
    end

    // R4: bypass passes the clock through on its high phase
    @(posedge clk);
    #2;
    check("R4 bypass clk_o high phase", int'(clk_o), 1);

    // R8: load from bypass on the next edge
    @(negedge clk);
    set_cfg(2, 1, 4, 2);
    @(negedge clk);
    check("R8 en_o first run cycle", int'(en_o), 0);
    check("R8 clk_o first run cycle", int'(clk_o), 1);
    ticks = 0;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      ticks += int'(en_o);
    end
    check("R8 ticks first period", ticks, 1);

    // R7: inputs ignored until wrap to zero
    @(negedge clk);
    set_cfg(2, 1, 8, 4);
    repeat (20) @(negedge clk);
    while (!en_o) @(negedge clk);
    set_cfg(0, 1, 8, 4);
    ok = 1;
    for (int c = 0; c < 7; c++) begin
      @(negedge clk);
      if (en_o) ok = 0;
    end
    check("R7 held config until wrap", ok, 1);
    @(negedge clk);
    check("R7 bypass after wrap", int'(en_o), 1);

    // R1: reset mid-run returns to bypass
    set_cfg(2, 3, 8, 4);
    repeat (30) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 en_o on reset mid-run", int'(en_o), 1);

    done = 1;
    finish_run();
  end
endmodule